// File: doc/BRIEF.md
# Memory-Resident Workspace Register Unit

This block keeps a processor's sixteen general registers in external RAM instead of in an on-chip register file. A base pointer register names the start of a block of sixteen consecutive 16-bit words. Register number n is the word at byte address base + 2*n. Writing a new base switches the whole register set in a single step, which makes a context switch one pointer write.

The unit carries out one operation, a register-to-register move, through a single-port word-wide memory interface. A move takes four busy cycles in a fixed order: a fetch cycle that captures the operation, a decode cycle that forms the source address, a read cycle that forms the destination address, and a write cycle that stores the word just read. Address arithmetic overlaps the decode and read cycles, so it adds no cycles. Because no register file or register multiplexer exists on chip, a move whose source and destination are the same register needs no special handling.

Top module: `wsreg_unit`

## Requirements
- R1: After a synchronous active-high reset, `busy` is 0, `wp_out` is 0 and `mem_req` is 0.
- R2: A pointer load (`wp_load` high) while the unit is idle sets `wp_out` on the next cycle to `wp_value` with bit 0 cleared.
- R3: A pointer load while `busy` is high is ignored, and `wp_out` keeps its value.
- R4: A move is accepted when `mv_start` is high while the unit is idle. From the next cycle `busy` is high for exactly four cycles. `mem_req` is low in the first two of these cycles. The third cycle is a read (`mem_req`=1, `mem_we`=0) and the fourth is a write (`mem_req`=1, `mem_we`=1). `busy` is low in the cycle after the write.
- R5: The read address is `wp_out` + 2*src and the write address is `wp_out` + 2*dst, both taken modulo 2^16. The source index src is `mv_instr[3:0]` and the destination index dst is `mv_instr[7:4]`. All other instruction bits are ignored.
- R6: In the write cycle, `mem_wdata` equals `mem_rdata`, which is the word returned one cycle after the read request.
- R7: `mv_start` is ignored while `busy` is high. No further move follows the current one.
- R8: A pointer load and a move start in the same idle cycle are both accepted, and the move uses the new pointer.
- R9: A move with src equal to dst reads and then writes the same address, with no other change to the sequence.
- R10: `mem_req` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mv_start | input | 1 | Request a move (accepted when idle) |
| mv_instr | input | 16 | Move word: src in [3:0], dst in [7:4] |
| wp_load | input | 1 | Request a pointer load (accepted when idle) |
| wp_value | input | 16 | New pointer value |
| busy | output | 1 | High from the fetch cycle through the write cycle |
| wp_out | output | 16 | Current workspace pointer |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address of the request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
Random moves with random source and destination fields, random pointer loads and random read data separate errors in the address scaling, in field selection and in data forwarding. Directed cases cover a source equal to the destination, a pointer near the top of the address space (which exposes a missing wrap or a lost carry), an odd pointer value (which shows whether bit 0 is cleared) and a pointer load in the same cycle as a start. Disturbance cases drive a start and a pointer load in the middle of a move. They show whether the sequence is protected against both, through the addresses the move uses and the idle state that follows it.

// File: rtl/wsreg_pkg.sv
package wsreg_pkg;

    parameter int WORD_W   = 16;
    parameter int ADDR_W   = 16;
    parameter int INSTR_W  = 16;
    parameter int NUM_REGS = 16;
    parameter int SRC_LSB  = 0;
    parameter int DST_LSB  = 4;

    localparam int IDX_W       = $clog2(NUM_REGS);
    localparam int BYTES_WORD  = WORD_W / 8;
    localparam int WORD_SHIFT  = $clog2(BYTES_WORD);

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_READ,
        ST_WRITE
    } seq_st_t;

    typedef struct packed {
        idx_t dst;
        idx_t src;
    } mv_fields_t;

    function automatic addr_t ws_slot(addr_t base, idx_t n);
        return base + (addr_t'(n) << WORD_SHIFT);
    endfunction

    function automatic addr_t align_ptr(addr_t v);
        return v & ~addr_t'(BYTES_WORD - 1);
    endfunction

    function automatic mv_fields_t split_instr(instr_t w);
        mv_fields_t f;
        f.src = w[SRC_LSB +: IDX_W];
        f.dst = w[DST_LSB +: IDX_W];
        return f;
    endfunction

endpackage

// File: rtl/wsreg_seq.sv
module wsreg_seq
    import wsreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output logic    accept,
    output seq_st_t state
);

    seq_st_t state_q, state_d;

    assign accept = (state_q == ST_IDLE) && start;
    assign state  = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_READ;
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R4
    AST_WRITE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE) |=> (state_q == ST_IDLE)); // R7

endmodule

// File: rtl/wsreg_ptr.sv
module wsreg_ptr
    import wsreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t value,
    input  logic  idle,
    output addr_t wp
);

    addr_t wp_q;

    always_ff @(posedge clk) begin
        if (rst)               wp_q <= '0;
        else if (load && idle) wp_q <= align_ptr(value);
    end

    assign wp = wp_q;

    AST_PTR_HELD_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(wp_q)); // R3

endmodule

// File: rtl/wsreg_agen.sv
module wsreg_agen
    import wsreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  instr_t  instr,
    input  seq_st_t state,
    input  addr_t   wp,
    output addr_t   src_addr,
    output addr_t   dst_addr
);

    instr_t     instr_q;
    mv_fields_t fields_q;
    addr_t      src_q, dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_q  <= '0;
            fields_q <= '0;
            src_q    <= '0;
            dst_q    <= '0;
        end else begin
            if (accept)               instr_q  <= instr;
            if (state == ST_FETCH)    fields_q <= split_instr(instr_q);
            if (state == ST_DECODE)   src_q    <= ws_slot(wp, fields_q.src);
            if (state == ST_READ)     dst_q    <= ws_slot(wp, fields_q.dst);
        end
    end

    assign src_addr = src_q;
    assign dst_addr = dst_q;

    AST_SRC_HELD_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ) |=> $stable(src_q)); // R5

endmodule

// File: rtl/wsreg_unit.sv
module wsreg_unit
    import wsreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mv_start,
    input  logic [15:0] mv_instr,
    input  logic        wp_load,
    input  logic [15:0] wp_value,
    output logic        busy,
    output logic [15:0] wp_out,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata
);

    seq_st_t state;
    logic    accept;
    addr_t   wp, src_addr, dst_addr;
    logic    idle;

    assign idle = (state == ST_IDLE);

    wsreg_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (mv_start),
        .accept (accept),
        .state  (state)
    );

    wsreg_ptr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .load  (wp_load),
        .value (wp_value),
        .idle  (idle),
        .wp    (wp)
    );

    wsreg_agen u_agen (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .instr    (mv_instr),
        .state    (state),
        .wp       (wp),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    assign busy      = !idle;
    assign wp_out    = wp;
    assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = mem_we ? dst_addr : src_addr;
    assign mem_wdata = mem_we ? mem_rdata : '0;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R10
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (mem_req && mem_we)); // R4
    AST_WRITE_ENDS_MOVE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !busy); // R4
    AST_START_BEGINS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && mv_start) |=> (busy && !mem_req)); // R4

endmodule

// File: tb/wsreg_unit_test.sv
module wsreg_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        mv_start;
    logic [15:0] mv_instr;
    logic        wp_load;
    logic [15:0] wp_value;
    logic        busy;
    logic [15:0] wp_out;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [15:0] exp_wp;

    always #4 clk = ~clk;

    wsreg_unit uut (
        .clk       (clk),
        .rst       (rst),
        .mv_start  (mv_start),
        .mv_instr  (mv_instr),
        .wp_load   (wp_load),
        .wp_value  (wp_value),
        .busy      (busy),
        .wp_out    (wp_out),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [15:0] slot(logic [15:0] base, logic [3:0] n);
        return base + {11'd0, n, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_ptr(input logic [15:0] v);
        @(negedge clk);
        wp_load = 1'b1; wp_value = v;
        @(negedge clk);
        wp_load = 1'b0;
        exp_wp = v & 16'hFFFE;
        chk(wp_out == exp_wp, "R2 pointer load", wp_out, exp_wp);
    endtask

    task automatic do_move(input logic [15:0] ins, input bit ld_with, input logic [15:0] ldv,
                           input bit disturb, input logic [15:0] rd);
        logic [3:0] s, d;
        s = ins[3:0];
        d = ins[7:4];
        @(negedge clk);
        mv_start = 1'b1; mv_instr = ins;
        wp_load = ld_with; wp_value = ldv;
        if (ld_with) exp_wp = ldv & 16'hFFFE;
        @(negedge clk);                       // fetch
        mv_start = 1'b0; wp_load = 1'b0;
        chk(busy && !mem_req, "R4 fetch cycle", {14'd0, busy, mem_req}, 16'h0002);
        if (ld_with) chk(wp_out == exp_wp, "R8 same-cycle load", wp_out, exp_wp);
        if (disturb) begin
            mv_start = 1'b1; mv_instr = ~ins;
            wp_load = 1'b1; wp_value = ldv ^ 16'h1235;
        end
        @(negedge clk);                       // decode
        mv_start = 1'b0; wp_load = 1'b0;
        chk(busy && !mem_req, "R4 decode cycle", {14'd0, busy, mem_req}, 16'h0002);
        if (disturb) chk(wp_out == exp_wp, "R3 load while busy", wp_out, exp_wp);
        @(negedge clk);                       // read
        chk(busy && mem_req && !mem_we, "R4 read cycle", {13'd0, busy, mem_req, mem_we}, 16'h0006);
        chk(mem_addr == slot(exp_wp, s), "R5 read address", mem_addr, slot(exp_wp, s));
        mem_rdata = rd;
        @(negedge clk);                       // write
        chk(busy && mem_req && mem_we, "R4 write cycle", {13'd0, busy, mem_req, mem_we}, 16'h0007);
        chk(mem_addr == slot(exp_wp, d), "R5 write address", mem_addr, slot(exp_wp, d));
        chk(mem_wdata == rd, "R6 write data", mem_wdata, rd);
        if (s == d) chk(mem_addr == slot(exp_wp, s), "R9 same register", mem_addr, slot(exp_wp, s));
        @(negedge clk);                       // idle again
        mem_rdata = 16'hDEAD;
        chk(!busy, "R7 back to idle", {15'd0, busy}, 16'h0000);
        chk(!mem_req, "R10 idle quiet", {15'd0, mem_req}, 16'h0000);
        chk(wp_out == exp_wp, "R3 pointer kept", wp_out, exp_wp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd2024);
        rst = 1'b1; mv_start = 1'b0; mv_instr = '0;
        wp_load = 1'b0; wp_value = '0; mem_rdata = '0;
        exp_wp = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && wp_out == 16'h0 && !mem_req, "R1 reset state",
            {busy, mem_req, wp_out[13:0]}, 16'h0000);

        do_move(16'h0021, 1'b0, 16'h0, 1'b0, 16'hBEEF);          // base 0
        load_ptr(16'h0101);                                       // odd value
        do_move(16'hFF35, 1'b0, 16'h0, 1'b0, 16'h1234);          // upper bits ignored
        do_move(16'h0077, 1'b0, 16'h0, 1'b0, 16'h5A5A);          // R9 src == dst
        load_ptr(16'hFFF0);
        do_move(16'h00F0, 1'b0, 16'h0, 1'b0, 16'hC001);          // wrap
        do_move(16'h0034, 1'b1, 16'h4000, 1'b0, 16'h7777);       // R8
        do_move(16'h0012, 1'b0, 16'h2000, 1'b1, 16'h9999);       // R3/R7 disturbance

        for (int i = 0; i < 40; i++) begin
            logic [15:0] ins, ldv, rd;
            bit ldw, dst;
            ins = 16'($urandom);
            ldv = 16'($urandom);
            rd  = 16'($urandom);
            ldw = 1'($urandom % 3 == 0);
            dst = 1'($urandom % 4 == 0);
            if ($urandom % 5 == 0) load_ptr(16'($urandom));
            do_move(ins, ldw, ldv, dst, rd);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule